// File: doc/BRIEF.md
# Write-Absorbing Register Value Buffer

This block sits between a pipeline's operand logic and a 32-entry, 32-bit register file. It keeps the most recently written register values in a small fully associative store, so that writes and most operand reads are served without touching the register file. New results always go into the store. When the store is full and a write brings in a register it does not hold, the entry whose last write is the oldest is pushed out to the register file through an eviction channel. The register file itself lives outside the block. Its two read data buses come back in as inputs.

A one-bit-per-register location map records whether each register's live value sits in the store (bit set) or in the register file (bit clear). Each of the two read ports uses its register's location bit to choose between the store's data and the register file's data within the same cycle, so a read that misses the store costs no extra cycle. A write in the current cycle is forwarded to any read of the same register. Register 0 is hard-wired to zero and never occupies an entry.

Top module: `age_regbuf`

## Requirements
- R1: While `clr` is high, no write is accepted and `ev_valid` stays low. After a clear, every location bit reads 0 and every read returns the register file's data, even for registers whose values were held in the store before the clear.
- R2: An enabled write (`wr_en`=1) to a nonzero register places `wr_data` in the store and does not drive the eviction channel unless R6 applies. From the next cycle on, reads of that register return the stored value and its location bit reads 1.
- R3: A read of a register whose location bit is 0 returns the matching register file input (`rf_a_data` or `rf_b_data`) combinationally, in the same cycle.
- R4: `loc_a`, `loc_b` and `loc_w` show the location bit of `rd_a_idx`, `rd_b_idx` and `wr_idx` respectively (1 = in store).
- R5: An enabled write to a register that the store already holds overwrites that entry in place. It evicts nothing, uses up no other entry, and makes that entry the most recently written one.
- R6: An enabled write to a nonzero register that the store does not hold, while all entries are occupied, drives `ev_valid`=1 in the same cycle. `ev_idx` and `ev_data` then carry the register number and value of the entry whose last write is the oldest. From the next cycle on, that register's location bit is 0 and its reads come from the register file.
- R7: Register 0 is never placed in the store. A write to it has no effect, evicts nothing and leaves `loc_w` at 0. Any read of register 0 returns zero.
- R8: When an enabled write to a nonzero register is presented, a read of that register in the same cycle returns `wr_data`.
- R9: With `wr_en`=0, the write-side inputs change neither the store, nor the location map, nor the eviction channel.
- R10: Whenever `ev_valid` is 0, `ev_idx` and `ev_data` are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr | input | 1 | Synchronous clear, active high |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 5 | Register number being written |
| wr_data | input | 32 | Value being written |
| rd_a_idx | input | 5 | Register number for read port A |
| rd_b_idx | input | 5 | Register number for read port B |
| rf_a_data | input | 32 | Register file data for `rd_a_idx` |
| rf_b_data | input | 32 | Register file data for `rd_b_idx` |
| opnd_a | output | 32 | Operand delivered on read port A |
| opnd_b | output | 32 | Operand delivered on read port B |
| loc_a | output | 1 | Location bit of `rd_a_idx` |
| loc_b | output | 1 | Location bit of `rd_b_idx` |
| loc_w | output | 1 | Location bit of `wr_idx` |
| ev_valid | output | 1 | Eviction write to the register file this cycle |
| ev_idx | output | 5 | Register number being written back |
| ev_data | output | 32 | Value being written back |

## Verification
Operands, location bits and the eviction channel are combinational, so they are due in the cycle that presents the inputs. The store contents and location bits that a write changes become visible one cycle later. The bench drives every input on the falling edge and samples all outputs a nanosecond later, before the next rising edge. It then advances its behavioural model, a write-age queue plus a per-register value table, as that rising edge would. Evictions written back into the modelled register file on the rising edge therefore show up as register file data from the following cycle on, which is the cycle where R6 expects them.

// File: rtl/age_regbuf_pkg.sv
package age_regbuf_pkg;

   // what the store does with the write port in a given cycle
   typedef enum logic [1:0] {
      WR_NONE  = 2'd0,
      WR_HIT   = 2'd1,
      WR_FILL  = 2'd2,
      WR_EVICT = 2'd3
   } wr_act_e;

endpackage

// File: rtl/age_regbuf_locmap.sv
module age_regbuf_locmap #(
   parameter int NREG = 32,
   parameter int RW   = 5
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          set_en,
   input  logic [RW-1:0] set_idx,
   input  logic          drop_en,
   input  logic [RW-1:0] drop_idx,
   input  logic [RW-1:0] q_a_idx,
   input  logic [RW-1:0] q_b_idx,
   input  logic [RW-1:0] q_w_idx,
   output logic          loc_a,
   output logic          loc_b,
   output logic          loc_w
);
   logic [NREG-1:0] map_q;

   always_ff @(posedge clk) begin
      if (clr) begin
         map_q <= '0;
      end else begin
         if (drop_en) map_q[drop_idx] <= 1'b0;
         if (set_en)  map_q[set_idx]  <= 1'b1;
      end
   end

   assign loc_a = map_q[q_a_idx];
   assign loc_b = map_q[q_b_idx];
   assign loc_w = map_q[q_w_idx];

   // R1: clear empties the map
   assert_clear_map_R1: assert property (@(posedge clk) clr |=> (map_q == '0));
   // R2: an accepted write marks its register as held in the store
   assert_write_marks_R2: assert property (@(posedge clk) disable iff (clr)
      set_en |=> map_q[$past(set_idx)]);
   // R6: an eviction hands the register back to the register file
   assert_evict_unmarks_R6: assert property (@(posedge clk) disable iff (clr)
      (drop_en && (drop_idx != set_idx)) |=> !map_q[$past(drop_idx)]);
endmodule

// File: rtl/age_regbuf_store.sv
module age_regbuf_store
   import age_regbuf_pkg::*;
#(
   parameter int DW   = 32,
   parameter int RW   = 5,
   parameter int NENT = 8
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          wr_go,
   input  logic [RW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [RW-1:0] rd_a_idx,
   input  logic [RW-1:0] rd_b_idx,
   output logic [DW-1:0] rd_a_data,
   output logic [DW-1:0] rd_b_data,
   output logic          hit_a,
   output logic          hit_b,
   output logic          ev_valid,
   output logic [RW-1:0] ev_idx,
   output logic [DW-1:0] ev_data
);
   localparam int AW = $clog2(NENT);
   localparam logic [AW-1:0] TAIL_RANK = AW'(NENT - 1);

   logic [NENT-1:0] vld;
   logic [RW-1:0]   tag  [NENT];
   logic [DW-1:0]   dat  [NENT];
   logic [AW-1:0]   rank [NENT];   // 0 = most recently written

   logic [NENT-1:0] hw, ha, hb, at_tail;
   logic [AW-1:0]   hit_sel, free_sel, vic_sel, tgt;
   logic [AW:0]     thr;
   wr_act_e         act;

   generate
      for (genvar e = 0; e < NENT; e++) begin : g_cam
         assign hw[e]      = vld[e] && (tag[e] == wr_idx);
         assign ha[e]      = vld[e] && (tag[e] == rd_a_idx);
         assign hb[e]      = vld[e] && (tag[e] == rd_b_idx);
         assign at_tail[e] = vld[e] && (rank[e] == TAIL_RANK);
      end
   endgenerate

   assign hit_a = |ha;
   assign hit_b = |hb;

   always_comb begin
      rd_a_data = '0;
      rd_b_data = '0;
      for (int e = 0; e < NENT; e++) begin
         if (ha[e]) rd_a_data = rd_a_data | dat[e];
         if (hb[e]) rd_b_data = rd_b_data | dat[e];
      end
   end

   always_comb begin
      hit_sel  = '0;
      free_sel = '0;
      vic_sel  = '0;
      for (int e = NENT - 1; e >= 0; e--) begin
         if (hw[e])      hit_sel  = AW'(e);
         if (!vld[e])    free_sel = AW'(e);
         if (at_tail[e]) vic_sel  = AW'(e);
      end
   end

   always_comb begin
      if (!wr_go)       act = WR_NONE;
      else if (|hw)     act = WR_HIT;
      else if (!(&vld)) act = WR_FILL;
      else              act = WR_EVICT;
   end

   // thr: entries younger than this rank age by one step
   always_comb begin
      case (act)
         WR_HIT:   begin tgt = hit_sel;  thr = {1'b0, rank[hit_sel]}; end
         WR_FILL:  begin tgt = free_sel; thr = (AW+1)'(NENT);       end
         WR_EVICT: begin tgt = vic_sel;  thr = (AW+1)'(NENT - 1);   end
         default:  begin tgt = '0;       thr = '0;                  end
      endcase
   end

   assign ev_valid = (act == WR_EVICT);
   assign ev_idx   = ev_valid ? tag[vic_sel] : '0;
   assign ev_data  = ev_valid ? dat[vic_sel] : '0;

   always_ff @(posedge clk) begin
      if (clr) begin
         vld <= '0;
      end else if (act != WR_NONE) begin
         for (int e = 0; e < NENT; e++) begin
            if (AW'(e) == tgt) begin
               vld[e]  <= 1'b1;
               tag[e]  <= wr_idx;
               dat[e]  <= wr_data;
               rank[e] <= '0;
            end else if (vld[e] && ({1'b0, rank[e]} < thr)) begin
               rank[e] <= rank[e] + 1'b1;
            end
         end
      end
   end

   // R5: a register never occupies two entries
   assert_single_copy_R5: assert property (@(posedge clk) disable iff (clr)
      ($countones(hw) <= 1) && ($countones(ha) <= 1) && ($countones(hb) <= 1));
   // R6: when full there is exactly one oldest entry
   assert_one_victim_R6: assert property (@(posedge clk) disable iff (clr)
      (&vld) |-> $onehot0(at_tail) && (at_tail != '0));
   // R10: the eviction channel is quiet when idle
   assert_quiet_channel_R10: assert property (@(posedge clk) disable iff (clr)
      !ev_valid |-> (ev_idx == '0) && (ev_data == '0));
endmodule

// File: rtl/age_regbuf_opmux.sv
module age_regbuf_opmux #(
   parameter int DW = 32,
   parameter int RW = 5
) (
   input  logic [RW-1:0] idx,
   input  logic          in_buf,
   input  logic [DW-1:0] buf_data,
   input  logic [DW-1:0] rf_data,
   input  logic          byp_en,
   input  logic [RW-1:0] byp_idx,
   input  logic [DW-1:0] byp_data,
   output logic [DW-1:0] opnd
);
   always_comb begin
      if (idx == '0)                      opnd = '0;
      else if (byp_en && byp_idx == idx)  opnd = byp_data;
      else if (in_buf)                    opnd = buf_data;
      else                                opnd = rf_data;
   end
endmodule

// File: rtl/age_regbuf.sv
module age_regbuf #(
   parameter int DW   = 32,
   parameter int NREG = 32,
   parameter int NENT = 8
) (
   input  logic                     clk,
   input  logic                     clr,
   input  logic                     wr_en,
   input  logic [$clog2(NREG)-1:0]  wr_idx,
   input  logic [DW-1:0]            wr_data,
   input  logic [$clog2(NREG)-1:0]  rd_a_idx,
   input  logic [$clog2(NREG)-1:0]  rd_b_idx,
   input  logic [DW-1:0]            rf_a_data,
   input  logic [DW-1:0]            rf_b_data,
   output logic [DW-1:0]            opnd_a,
   output logic [DW-1:0]            opnd_b,
   output logic                     loc_a,
   output logic                     loc_b,
   output logic                     loc_w,
   output logic                     ev_valid,
   output logic [$clog2(NREG)-1:0]  ev_idx,
   output logic [DW-1:0]            ev_data
);
   localparam int RW = $clog2(NREG);
   localparam int NRD = 2;

   generate
      if (NENT < 2)          begin : g_chk_depth $error("NENT must be at least 2"); end
      if (NENT >= NREG)      begin : g_chk_fit   $error("NENT must be below NREG"); end
      if (NREG != (1 << RW)) begin : g_chk_pow2  $error("NREG must be a power of two"); end
      if (DW < 1)            begin : g_chk_width $error("DW must be positive"); end
   endgenerate

   logic          wr_go;
   logic          hit_a, hit_b;
   logic [DW-1:0] sto_a, sto_b;

   assign wr_go = wr_en && !clr && (wr_idx != '0);

   age_regbuf_store #(.DW(DW), .RW(RW), .NENT(NENT)) u_store (
      .clk      (clk),
      .clr      (clr),
      .wr_go    (wr_go),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .rd_a_idx (rd_a_idx),
      .rd_b_idx (rd_b_idx),
      .rd_a_data(sto_a),
      .rd_b_data(sto_b),
      .hit_a    (hit_a),
      .hit_b    (hit_b),
      .ev_valid (ev_valid),
      .ev_idx   (ev_idx),
      .ev_data  (ev_data)
   );

   age_regbuf_locmap #(.NREG(NREG), .RW(RW)) u_map (
      .clk     (clk),
      .clr     (clr),
      .set_en  (wr_go),
      .set_idx (wr_idx),
      .drop_en (ev_valid),
      .drop_idx(ev_idx),
      .q_a_idx (rd_a_idx),
      .q_b_idx (rd_b_idx),
      .q_w_idx (wr_idx),
      .loc_a   (loc_a),
      .loc_b   (loc_b),
      .loc_w   (loc_w)
   );

   logic [RW-1:0] rd_idx [NRD];
   logic          rd_loc [NRD];
   logic [DW-1:0] rd_sto [NRD];
   logic [DW-1:0] rd_rf  [NRD];
   logic [DW-1:0] rd_op  [NRD];

   assign rd_idx[0] = rd_a_idx;  assign rd_idx[1] = rd_b_idx;
   assign rd_loc[0] = loc_a;     assign rd_loc[1] = loc_b;
   assign rd_sto[0] = sto_a;     assign rd_sto[1] = sto_b;
   assign rd_rf[0]  = rf_a_data; assign rd_rf[1]  = rf_b_data;

   generate
      for (genvar p = 0; p < NRD; p++) begin : g_port
         age_regbuf_opmux #(.DW(DW), .RW(RW)) u_mux (
            .idx     (rd_idx[p]),
            .in_buf  (rd_loc[p]),
            .buf_data(rd_sto[p]),
            .rf_data (rd_rf[p]),
            .byp_en  (wr_go),
            .byp_idx (wr_idx),
            .byp_data(wr_data),
            .opnd    (rd_op[p])
         );
      end
   endgenerate

   assign opnd_a = rd_op[0];
   assign opnd_b = rd_op[1];

   // R4: location map and store agree on which registers are held
   assert_map_agrees_a_R4: assert property (@(posedge clk) disable iff (clr) loc_a == hit_a);
   assert_map_agrees_b_R4: assert property (@(posedge clk) disable iff (clr) loc_b == hit_b);
   // R7: register 0 is never held and never evicted
   assert_zero_unheld_R7: assert property (@(posedge clk) disable iff (clr)
      (wr_idx == '0) |-> !loc_w && !ev_valid);
   // R1: nothing leaves the block during a clear
   assert_clear_no_evict_R1: assert property (@(posedge clk) clr |-> !ev_valid);
endmodule

// File: tb/age_regbuf_test.sv
`timescale 1ns/1ps
module age_regbuf_test;
   localparam int NENT = 8;

   logic        clk = 1'b0;
   logic        clr = 1'b1;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic [4:0]  rd_a_idx = '0;
   logic [4:0]  rd_b_idx = '0;
   logic [31:0] rf_a_data, rf_b_data;
   logic [31:0] opnd_a, opnd_b;
   logic        loc_a, loc_b, loc_w;
   logic        ev_valid;
   logic [4:0]  ev_idx;
   logic [31:0] ev_data;

   always #10 clk = ~clk;   // 50 MHz

   age_regbuf uut (
      .clk(clk), .clr(clr), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
      .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
      .opnd_a(opnd_a), .opnd_b(opnd_b),
      .loc_a(loc_a), .loc_b(loc_b), .loc_w(loc_w),
      .ev_valid(ev_valid), .ev_idx(ev_idx), .ev_data(ev_data)
   );

   // register file environment, written back through the eviction channel
   logic [31:0] rf [32];
   initial for (int i = 0; i < 32; i++) rf[i] = 32'hA000_0000 + i;
   assign rf_a_data = rf[rd_a_idx];
   assign rf_b_data = rf[rd_b_idx];
   always @(posedge clk) if (ev_valid) rf[ev_idx] <= ev_data;

   // behavioural reference
   logic [31:0] mrf  [32];
   logic [31:0] mval [32];
   bit          held [32];
   int          age_q [$];   // front = oldest write
   initial for (int i = 0; i < 32; i++) begin mrf[i] = 32'hA000_0000 + i; held[i] = 0; end

   int    total = 0;
   int    bad = 0;
   string phase = "INIT";

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s/%s %s: actual=%h expected=%h", phase, tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(int r, bit we, int wa, logic [31:0] wd);
      if (r == 0) return 32'h0;
      if (we && wa == r) return wd;
      if (held[r]) return mval[r];
      return mrf[r];
   endfunction

   function automatic string rd_tag(int r, bit we, int wa);
      if (r == 0) return "R7";
      if (we && wa == r) return "R8";
      if (held[r]) return "R2";
      return "R3";
   endfunction

   task automatic step(bit we, int wa, logic [31:0] wd, int ra, int rb);
      bit evx;
      int vic;
      @(negedge clk);
      clr = 1'b0;
      wr_en = we; wr_idx = wa[4:0]; wr_data = wd;
      rd_a_idx = ra[4:0]; rd_b_idx = rb[4:0];
      #1;
      chk(rd_tag(ra, we, wa), "opnd_a", opnd_a, exp_rd(ra, we, wa, wd));
      chk(rd_tag(rb, we, wa), "opnd_b", opnd_b, exp_rd(rb, we, wa, wd));
      chk("R4", "loc_a", {31'h0, loc_a}, {31'h0, held[ra]});
      chk("R4", "loc_b", {31'h0, loc_b}, {31'h0, held[rb]});
      chk("R4", "loc_w", {31'h0, loc_w}, {31'h0, held[wa]});
      evx = we && wa != 0 && !held[wa] && age_q.size() == NENT;
      vic = evx ? age_q[0] : 0;
      chk(evx ? "R6" : "R10", "ev_valid", {31'h0, ev_valid}, {31'h0, evx});
      chk(evx ? "R6" : "R10", "ev_idx", {27'h0, ev_idx}, vic);
      chk(evx ? "R6" : "R10", "ev_data", ev_data, evx ? mval[vic] : 32'h0);
      // advance model as the rising edge will
      if (we && wa != 0) begin
         if (held[wa]) begin
            for (int i = 0; i < age_q.size(); i++)
               if (age_q[i] == wa) begin age_q.delete(i); break; end
         end else if (evx) begin
            void'(age_q.pop_front());
            mrf[vic] = mval[vic];
            held[vic] = 0;
         end
         age_q.push_back(wa);
         held[wa] = 1;
         mval[wa] = wd;
      end
   endtask

   task automatic do_clear();
      @(negedge clk);
      clr = 1'b1;
      wr_en = 1'b1; wr_idx = 5'd17; wr_data = 32'h5555_AAAA;   // must be ignored
      #1;
      chk("R1", "ev_valid during clear", {31'h0, ev_valid}, 32'h0);
      age_q.delete();
      for (int i = 0; i < 32; i++) held[i] = 0;
   endtask

   initial begin
      repeat (3) @(posedge clk);

      phase = "R1";
      do_clear();
      step(0, 0, 0, 1, 2);
      step(0, 0, 0, 17, 31);

      phase = "R2";
      for (int i = 1; i <= NENT; i++) step(1, i, 32'h1000 + i, i, i + 1);
      step(0, 0, 0, 3, 5);
      step(0, 0, 0, 8, 9);

      phase = "R5";
      step(1, 3, 32'h3333_0003, 3, 4);
      step(0, 0, 0, 3, 1);

      phase = "R6";
      step(1, 9, 32'h9999_0009, 1, 9);    // evicts 1
      step(1, 10, 32'hAAAA_000A, 1, 2);   // evicts 2
      step(1, 11, 32'hBBBB_000B, 3, 4);   // evicts 4: 3 was rewritten later
      step(0, 0, 0, 4, 3);
      step(0, 0, 0, 1, 2);

      phase = "R7";
      step(1, 0, 32'hFFFF_FFFF, 0, 0);
      step(0, 0, 0, 0, 9);

      phase = "R9";
      step(0, 5, 32'h0BAD_0BAD, 5, 12);
      step(0, 12, 32'h0BAD_0BAD, 5, 12);

      phase = "R8";
      step(1, 12, 32'hC0DE_000C, 12, 12);
      step(0, 0, 0, 12, 6);

      phase = "R1";
      do_clear();
      step(0, 0, 0, 9, 17);
      step(0, 0, 0, 12, 3);

      phase = "RND";
      for (int n = 0; n < 4000; n++)
         step(($urandom_range(0, 9) < 7), $urandom_range(0, 15), $urandom(),
              $urandom_range(0, 15), $urandom_range(0, 15));

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule